// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the device-side input stage of a small NAND-style flash. It watches an 8-bit multiplexed I/O bus and takes one byte on every rising edge of the active-low write strobe, but only while chip enable is low. Two latch-enable pins decide how each byte is used. With only the command latch high, the byte is a command. With only the address latch high, it is an address. Any other combination is a data byte, or is not valid, and the decoder ignores it. The write strobe is brought into the block clock domain through a short synchronizer.

The block recognises read (first half, second half, spare area), page program, block erase, read ID, read status and reset. It collects the column byte and two row bytes of each operation. It also tracks which part of the page register the next column byte refers to. When a sequence is complete, it raises a request carrying the operation kind and the resolved column and row. That request stays up until the array back end acknowledges it. The cell array, operation timing, busy signalling and data output sit behind that handshake.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus byte is taken only on a rising edge of `we_n` while `ce_n` is low. Writes made with `ce_n` high change nothing.
- R2: A byte is a command when `cle`=1 and `ale`=0, and an address when `ale`=1 and `cle`=0. Bytes with both high or both low do not advance or disturb a command/address sequence.
- R3: Command 00h followed by three address bytes (column, row low, row high) issues a read, `op_kind`=1. The column is the first byte. The row is {row-high byte bits 4:0, row-low byte}.
- R4: Command 01h sets `ptr_half`=1 and makes the column 256 + column byte. Once a read or program using it has been issued, `ptr_half` returns to 0.
- R5: Command 50h is accepted only while `spare_sel_n` is low. It sets `ptr_half`=2, and the column becomes 512 + the low 4 bits of the column byte. With `spare_sel_n` high, the command is ignored.
- R6: Command 60h, then two row bytes, then D0h issues an erase, `op_kind`=3, with column 0. The row has its low 4 bits forced to zero (16-page blocks). No request is raised before D0h.
- R7: Command 80h, then three address bytes, any data bytes, then 10h issues a program, `op_kind`=2, with the column and row formed as for a read.
- R8: FFh, 90h and 70h take effect immediately, with `op_kind` 6, 4 and 5 respectively. Any other command code is ignored and leaves a pending sequence intact.
- R9: A recognised command arriving in the middle of a sequence abandons that sequence. A confirm byte (10h or D0h) without its complete setup issues nothing.
- R10: A request holds `op_valid`, `op_kind`, `op_col` and `op_row` until `op_ack`. While it is held, every byte except FFh is ignored. FFh replaces the pending request with a reset request.
- R11: The reset command returns `ptr_half` to 0 and clears any partial sequence.
- R12: After `rst_n` is released, `op_valid`=0 and `ptr_half`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe; the byte is taken on its rising edge |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io_in | input | 8 | Multiplexed command/address/data bus |
| spare_sel_n | input | 1 | Spare-area read enable, active low |
| op_ack | input | 1 | Back end accepts the pending request |
| op_valid | output | 1 | Operation request pending |
| op_kind | output | 3 | 1 read, 2 program, 3 erase, 4 ID, 5 status, 6 reset |
| op_col | output | 10 | Resolved column, 0..527 |
| op_row | output | 13 | Page address |
| ptr_half | output | 2 | Register pointer: 0 first half, 1 second half, 2 spare |

## Verification
The bench targets the column offset. A decoder that loses the one-shot return of the second-half pointer would put the next plain read 256 columns too high. A decoder that accepts the spare command while it is inhibited would shift the column into the 512 range. Erase tests use rows with non-zero low bits, so a missing block alignment shows up directly in `op_row`. Other tests place an illegal code, a data byte and a `ce_n`-high write inside an address sequence, and start a new command halfway through an erase, so that a miscounting decoder issues the wrong operation or a wrong row. A held request is hit with unrelated commands and then with reset. This exposes a design that overwrites requests or lets reset wait behind them.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;

    localparam int IO_W       = 8;
    localparam int COL_W      = IO_W + 2;
    localparam int ROW_W      = 13;
    localparam int ROW_HI_W   = ROW_W - IO_W;
    localparam int SPARE_BITS = 4;
    localparam int BLK_BITS   = 4;

    localparam logic [IO_W-1:0] CODE_RD_A    = 8'h00;
    localparam logic [IO_W-1:0] CODE_RD_B    = 8'h01;
    localparam logic [IO_W-1:0] CODE_RD_SP   = 8'h50;
    localparam logic [IO_W-1:0] CODE_RST     = 8'hFF;
    localparam logic [IO_W-1:0] CODE_ID      = 8'h90;
    localparam logic [IO_W-1:0] CODE_STAT    = 8'h70;
    localparam logic [IO_W-1:0] CODE_PG_SET  = 8'h80;
    localparam logic [IO_W-1:0] CODE_PG_GO   = 8'h10;
    localparam logic [IO_W-1:0] CODE_ER_SET  = 8'h60;
    localparam logic [IO_W-1:0] CODE_ER_GO   = 8'hD0;

    typedef enum logic [3:0] {
        CMD_NONE, CMD_RD_A, CMD_RD_B, CMD_RD_SP, CMD_RST, CMD_ID,
        CMD_STAT, CMD_PG_SET, CMD_PG_GO, CMD_ER_SET, CMD_ER_GO
    } cmd_t;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0, OP_READ = 3'd1, OP_PROG = 3'd2, OP_ERASE = 3'd3,
        OP_ID = 3'd4, OP_STAT = 3'd5, OP_RESET = 3'd6
    } op_t;

    typedef enum logic [1:0] {
        PTR_A = 2'd0, PTR_B = 2'd1, PTR_SP = 2'd2
    } ptr_t;

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_RD_ADDR, SEQ_PG_ADDR, SEQ_PG_DATA, SEQ_ER_ADDR, SEQ_ER_CONF
    } seq_t;

endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic strobe
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], we_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign strobe = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R1
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_front_pkg::*;
(
    input  logic [IO_W-1:0] code,
    input  logic            spare_sel_n,
    output cmd_t            cmd
);
    always_comb begin
        unique case (code)
            CODE_RD_A:   cmd = CMD_RD_A;
            CODE_RD_B:   cmd = CMD_RD_B;
            CODE_RD_SP:  cmd = spare_sel_n ? CMD_NONE : CMD_RD_SP;
            CODE_RST:    cmd = CMD_RST;
            CODE_ID:     cmd = CMD_ID;
            CODE_STAT:   cmd = CMD_STAT;
            CODE_PG_SET: cmd = CMD_PG_SET;
            CODE_PG_GO:  cmd = CMD_PG_GO;
            CODE_ER_SET: cmd = CMD_ER_SET;
            CODE_ER_GO:  cmd = CMD_ER_GO;
            default:     cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm
    import nand_front_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic [IO_W-1:0]     din,
    output logic [IO_W-1:0]     byte0,
    output logic [IO_W-1:0]     byte1,
    output logic [ROW_HI_W-1:0] byte2,
    output logic [1:0]          count
);
    typedef struct packed {
        logic [IO_W-1:0]     b0;
        logic [IO_W-1:0]     b1;
        logic [ROW_HI_W-1:0] b2;
        logic [1:0]          cnt;
    } asm_t;

    asm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (load && s_q.cnt != 2'd3) begin
            unique case (s_q.cnt)
                2'd0:    s_d.b0 = din;
                2'd1:    s_d.b1 = din;
                default: s_d.b2 = din[ROW_HI_W-1:0];
            endcase
            s_d.cnt = s_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte0 = s_q.b0;
    assign byte1 = s_q.b1;
    assign byte2 = s_q.b2;
    assign count = s_q.cnt;
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [IO_W-1:0]  io_in,
    input  logic             spare_sel_n,
    input  logic             op_ack,
    output logic             op_valid,
    output logic [2:0]       op_kind,
    output logic [COL_W-1:0] op_col,
    output logic [ROW_W-1:0] op_row,
    output logic [1:0]       ptr_half
);
    localparam int HALF = 1 << IO_W;

    typedef struct packed {
        seq_t             seq;
        ptr_t             ptr;
        logic             valid;
        op_t              kind;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } front_t;

    front_t st_d, st_q;

    logic                strobe, wr_en;
    cmd_t                cmd;
    logic                asm_clr, asm_load;
    logic [IO_W-1:0]     a_b0, a_b1;
    logic [ROW_HI_W-1:0] a_b2;
    logic [1:0]          a_cnt;

    nand_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .strobe(strobe)
    );

    nand_cmd_decode dec_i (
        .code(io_in), .spare_sel_n(spare_sel_n), .cmd(cmd)
    );

    nand_addr_asm asm_i (
        .clk(clk), .rst_n(rst_n), .clr(asm_clr), .load(asm_load), .din(io_in),
        .byte0(a_b0), .byte1(a_b1), .byte2(a_b2), .count(a_cnt)
    );

    assign wr_en = strobe & ~ce_n;

    function automatic logic [COL_W-1:0] col_of(ptr_t p, logic [IO_W-1:0] b);
        logic [COL_W-1:0] c;
        unique case (p)
            PTR_B:   c = COL_W'(HALF) + COL_W'(b);
            PTR_SP:  c = COL_W'(2 * HALF) + COL_W'(b[SPARE_BITS-1:0]);
            default: c = COL_W'(b);
        endcase
        return c;
    endfunction

    always_comb begin
        st_d     = st_q;
        asm_clr  = 1'b0;
        asm_load = 1'b0;
        if (op_ack) st_d.valid = 1'b0;

        if (wr_en && cle && !ale && cmd != CMD_NONE &&
            (!st_q.valid || cmd == CMD_RST)) begin
            asm_clr  = 1'b1;
            st_d.seq = SEQ_IDLE;
            unique case (cmd)
                CMD_RD_A:   begin st_d.ptr = PTR_A;  st_d.seq = SEQ_RD_ADDR; end
                CMD_RD_B:   begin st_d.ptr = PTR_B;  st_d.seq = SEQ_RD_ADDR; end
                CMD_RD_SP:  begin st_d.ptr = PTR_SP; st_d.seq = SEQ_RD_ADDR; end
                CMD_PG_SET: st_d.seq = SEQ_PG_ADDR;
                CMD_ER_SET: st_d.seq = SEQ_ER_ADDR;
                CMD_RST: begin
                    st_d.ptr   = PTR_A;
                    st_d.valid = 1'b1;
                    st_d.kind  = OP_RESET;
                    st_d.col   = '0;
                    st_d.row   = '0;
                end
                CMD_ID, CMD_STAT: begin
                    st_d.valid = 1'b1;
                    st_d.kind  = (cmd == CMD_ID) ? OP_ID : OP_STAT;
                    st_d.col   = '0;
                    st_d.row   = '0;
                end
                CMD_PG_GO: begin
                    if (st_q.seq == SEQ_PG_DATA) begin
                        st_d.valid = 1'b1;
                        st_d.kind  = OP_PROG;
                        st_d.col   = col_of(st_q.ptr, a_b0);
                        st_d.row   = {a_b2, a_b1};
                        if (st_q.ptr == PTR_B) st_d.ptr = PTR_A;
                    end
                end
                CMD_ER_GO: begin
                    if (st_q.seq == SEQ_ER_CONF) begin
                        st_d.valid = 1'b1;
                        st_d.kind  = OP_ERASE;
                        st_d.col   = '0;
                        st_d.row   = {a_b1[ROW_HI_W-1:0], a_b0[IO_W-1:BLK_BITS],
                                      {BLK_BITS{1'b0}}};
                    end
                end
                default: ;
            endcase
        end else if (wr_en && ale && !cle && !st_q.valid) begin
            unique case (st_q.seq)
                SEQ_RD_ADDR: begin
                    asm_load = 1'b1;
                    if (a_cnt == 2'd2) begin
                        st_d.valid = 1'b1;
                        st_d.kind  = OP_READ;
                        st_d.col   = col_of(st_q.ptr, a_b0);
                        st_d.row   = {io_in[ROW_HI_W-1:0], a_b1};
                        st_d.seq   = SEQ_IDLE;
                        if (st_q.ptr == PTR_B) st_d.ptr = PTR_A;
                    end
                end
                SEQ_PG_ADDR: begin
                    asm_load = 1'b1;
                    if (a_cnt == 2'd2) st_d.seq = SEQ_PG_DATA;
                end
                SEQ_ER_ADDR: begin
                    asm_load = 1'b1;
                    if (a_cnt == 2'd1) st_d.seq = SEQ_ER_CONF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.seq   <= SEQ_IDLE;
            st_q.ptr   <= PTR_A;
            st_q.kind  <= OP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_valid = st_q.valid;
    assign op_kind  = st_q.kind;
    assign op_col   = st_q.col;
    assign op_row   = st_q.row;
    assign ptr_half = st_q.ptr;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ack |=> op_valid);

    // R10
    req_kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ack |=> (op_kind == $past(op_kind)) || (op_kind == OP_RESET));

    // R6
    erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == OP_ERASE |-> op_row[BLK_BITS-1:0] == '0);

    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_col < COL_W'(2 * HALF + (1 << SPARE_BITS)));

endmodule

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
    logic [7:0] io_in = '0;
    logic       spare_sel_n = 1'b1, op_ack = 1'b0;
    logic       op_valid;
    logic [2:0] op_kind;
    logic [9:0] op_col;
    logic [12:0] op_row;
    logic [1:0] ptr_half;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nand_cmd_front dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io_in(io_in), .spare_sel_n(spare_sel_n), .op_ack(op_ack),
        .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col), .op_row(op_row),
        .ptr_half(ptr_half)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input bit c, input bit a, input logic [7:0] b, input bit ce_hi = 1'b0);
        @(negedge clk);
        ce_n = ce_hi; cle = c; ale = a; io_in = b; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] b); bus_wr(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b); bus_wr(1'b0, 1'b1, b); endtask

    task automatic expect_op(input string tag, input int k, input int c, input int r,
                             input bit do_ack = 1'b1);
        check(op_valid === 1'b1, {tag, " valid"}, op_valid, 1);
        check(op_kind == 3'(k), {tag, " kind"}, op_kind, k);
        check(op_col == 10'(c), {tag, " col"}, op_col, c);
        check(op_row == 13'(r), {tag, " row"}, op_row, r);
        if (do_ack) begin
            @(negedge clk); op_ack = 1'b1;
            @(negedge clk); op_ack = 1'b0;
            check(op_valid === 1'b0, {tag, " cleared by ack"}, op_valid, 0);
        end
    endtask

    task automatic expect_idle(input string tag);
        check(op_valid === 1'b0, {tag, " no request"}, op_valid, 0);
    endtask

    task automatic t_reset_state();
        check(op_valid === 1'b0, "R12 op_valid after reset", op_valid, 0);
        check(ptr_half == 2'd0, "R12 ptr after reset", ptr_half, 0);
    endtask

    task automatic t_read_first();
        cmd(8'h00); adr(8'h2A); adr(8'h34);
        expect_idle("R3 before last address");
        adr(8'h1F);
        expect_op("R3 read", 1, 8'h2A, 13'h1F34);
        check(ptr_half == 2'd0, "R3 ptr", ptr_half, 0);
    endtask

    task automatic t_read_second();
        cmd(8'h01);
        check(ptr_half == 2'd1, "R4 ptr set", ptr_half, 1);
        adr(8'h05); adr(8'h00); adr(8'h00);
        expect_op("R4 second half read", 1, 261, 0);
        check(ptr_half == 2'd0, "R4 ptr reverted", ptr_half, 0);
    endtask

    task automatic t_spare();
        spare_sel_n = 1'b1;
        cmd(8'h50);
        check(ptr_half == 2'd0, "R5 inhibited 50h ptr", ptr_half, 0);
        adr(8'h01); adr(8'h01); adr(8'h01);
        expect_idle("R5 inhibited 50h");
        spare_sel_n = 1'b0;
        cmd(8'h50);
        check(ptr_half == 2'd2, "R5 spare ptr", ptr_half, 2);
        adr(8'hF7); adr(8'h01); adr(8'h02);
        expect_op("R5 spare read", 1, 519, 13'h0201);
        check(ptr_half == 2'd2, "R5 spare ptr kept", ptr_half, 2);
        spare_sel_n = 1'b1;
        cmd(8'h00);
    endtask

    task automatic t_erase();
        cmd(8'h60); adr(8'h9B); adr(8'h13);
        expect_idle("R6 before confirm");
        cmd(8'hD0);
        expect_op("R6 erase", 3, 0, 13'h1390);
    endtask

    task automatic t_program();
        cmd(8'h80); adr(8'h10); adr(8'h22); adr(8'h03);
        bus_wr(1'b0, 1'b0, 8'hAA); bus_wr(1'b0, 1'b0, 8'h55);
        expect_idle("R7 before confirm");
        cmd(8'h10);
        expect_op("R7 program", 2, 16, 13'h0322);
        cmd(8'h01); cmd(8'h80); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'h10);
        expect_op("R7 R4 program second half", 2, 257, 0);
        check(ptr_half == 2'd0, "R4 ptr after program", ptr_half, 0);
    endtask

    task automatic t_single();
        cmd(8'hFF); expect_op("R8 reset", 6, 0, 0);
        cmd(8'h90); expect_op("R8 id", 4, 0, 0);
        cmd(8'h70); expect_op("R8 status", 5, 0, 0);
        cmd(8'h33); expect_idle("R8 illegal code");
        cmd(8'h00); adr(8'h11); cmd(8'h33); adr(8'h22); adr(8'h01);
        expect_op("R8 illegal mid-sequence", 1, 8'h11, 13'h0122);
    endtask

    task automatic t_abort();
        cmd(8'h60); adr(8'h40); cmd(8'h00);
        adr(8'h01); adr(8'h02); adr(8'h03);
        expect_op("R9 aborted erase", 1, 1, 13'h0302);
        cmd(8'hD0); expect_idle("R9 orphan D0h");
        cmd(8'h10); expect_idle("R9 orphan 10h");
    endtask

    task automatic t_ce_and_latches();
        bus_wr(1'b1, 1'b0, 8'h70, 1'b1);
        expect_idle("R1 ce_n high command");
        cmd(8'h00); adr(8'h01);
        bus_wr(1'b0, 1'b1, 8'h77, 1'b1);
        adr(8'h02); adr(8'h03);
        expect_op("R1 ce_n high address skipped", 1, 1, 13'h0302);
        bus_wr(1'b1, 1'b1, 8'h70);
        expect_idle("R2 both latches high");
        cmd(8'h00); adr(8'h04);
        bus_wr(1'b0, 1'b0, 8'h99);
        bus_wr(1'b1, 1'b1, 8'h05);
        adr(8'h05); adr(8'h06);
        expect_op("R2 data byte in address phase", 1, 4, 13'h0605);
    endtask

    task automatic t_busy();
        cmd(8'h70);
        expect_op("R10 status pending", 5, 0, 0, 1'b0);
        cmd(8'h90);
        expect_op("R10 id while busy", 5, 0, 0, 1'b0);
        cmd(8'h01);
        check(ptr_half == 2'd0, "R10 pointer unchanged while busy", ptr_half, 0);
        cmd(8'hFF);
        expect_op("R10 reset overrides", 6, 0, 0);
        cmd(8'h01);
        check(ptr_half == 2'd1, "R11 ptr before reset", ptr_half, 1);
        adr(8'h07);
        cmd(8'hFF);
        expect_op("R11 reset op", 6, 0, 0);
        check(ptr_half == 2'd0, "R11 ptr after reset", ptr_half, 0);
        adr(8'h01); adr(8'h02);
        expect_idle("R11 partial sequence cleared");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_read_first();
        t_read_second();
        t_spare();
        t_erase();
        t_program();
        t_single();
        t_abort();
        t_ce_and_latches();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule